// File: doc/BRIEF.md
# Parallel Poll Responder

This block answers parallel polls for an IEEE-488 talker/listener controller. Software loads a small poll configuration by writing an auxiliary command byte. The top three bits of that byte act as an opcode. The low five bits carry three fields:

- an unconfigure flag,
- a sense bit that chooses in-phase or reverse-phase matching,
- a three-bit index that picks one of the eight data lines.

The configuration is held in a register, and a readback port exposes it.

A parallel poll is present when the attention and end-or-identify inputs are both asserted. While it lasts, the block compares the local individual-status bit (ist) with the sense bit. On a match, and only when it is configured, it asserts one data-line pull request. On the same cycles it switches the line drivers from three-state to open-collector. All outputs are registered. They follow the poll condition by one clock and fall one clock after it ends.

Top module: `ppoll_responder`

## Requirements
- R1: While reset is applied, and until the synchronised reset releases, the readback `cfg_rd` (bit 4 = unconfigure U, bit 3 = sense S, bits 2..0 = index P) shows 5'b10000, and `dio_pull_low` and `dio_open_drain` are 0.
- R2: A write with `aux_wr`=1 and `aux_data[7:5]`=3'b011 makes `cfg_rd` equal `aux_data[4:0]` on the next clock.
- R3: A write whose `aux_data[7:5]` is not 3'b011 leaves `cfg_rd` unchanged.
- R4: While U=1 (for example after writing 8'b0111_0000), `dio_pull_low` stays all zero during a poll.
- R5: With U=0 and S=1, the selected line is pulled during a poll only when ist=1.
- R6: With U=0 and S=0, the selected line is pulled during a poll only when ist=0.
- R7: The pulled line is bit P of `dio_pull_low`: bit 0 is DIO1 and bit 7 is DIO8. A 1 requests that the line be driven low, which is logic one on the bus.
- R8: The response appears on the clock after `atn` and `eoi` are both seen high. It clears on the clock after either of them is seen low. Neither input alone produces a response.
- R9: `dio_open_drain` is 1 exactly on the cycles that follow a clock at which `atn` and `eoi` were both high. It is 0 at all other times.
- R10: At most one bit of `dio_pull_low` is 1 in any cycle.
- R11: ist is sampled on every clock during a poll, so a change of ist changes the response on the next clock. The response uses the configuration held before a write made at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| aux_wr | input | 1 | Strobe for an auxiliary command byte |
| aux_data | input | 8 | Auxiliary command byte |
| ist | input | 1 | Local individual-status bit |
| atn | input | 1 | Attention, asserted high |
| eoi | input | 1 | End-or-identify, asserted high |
| dio_pull_low | output | 8 | Per-line pull-low request, bit i = DIO(i+1) |
| dio_open_drain | output | 1 | 1 selects open-collector drivers, 0 selects three-state |
| cfg_rd | output | 5 | Stored {U, S, P} |

## Verification
A corrupted configuration bit appears on `cfg_rd` on the clock after the write that set it. It is also seen at the first poll, as a missing response, a response at the wrong polarity, or a pull on the wrong line. A broken poll register shows as a mismatch between `dio_open_drain` and the poll condition one clock after any change of `atn` or `eoi`. The scoreboard compares all three outputs on every clock. The stimulus sweeps every index, both senses, both ist values, partial poll conditions and rejected opcodes, so any such fault is reported within one cycle of the stimulus that reveals it.

// File: rtl/ppoll_pkg.sv
package ppoll_pkg;
  localparam int unsigned DIO_LINES = 8;
  localparam int unsigned IDX_W     = $clog2(DIO_LINES);
  localparam int unsigned CMD_W     = 8;
  localparam int unsigned OP_W      = 3;
  localparam logic [OP_W-1:0] OP_PP_CFG = 3'b011;
  localparam int unsigned CFG_W     = IDX_W + 2;

  typedef struct packed {
    logic             unc;
    logic             sense;
    logic [IDX_W-1:0] line;
  } ppoll_cfg_t;

  localparam ppoll_cfg_t CFG_RESET = '{unc: 1'b1, sense: 1'b0, line: '0};
endpackage

// File: rtl/ppoll_rst_sync.sv
module ppoll_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ppoll_cfg_reg.sv
module ppoll_cfg_reg
  import ppoll_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             aux_wr,
  input  logic [CMD_W-1:0] aux_data,
  output ppoll_cfg_t       cfg_q
);
  logic       load_en;
  ppoll_cfg_t cfg_d;

  always_comb begin
    load_en = aux_wr && (aux_data[CMD_W-1 -: OP_W] == OP_PP_CFG);
    cfg_d   = cfg_q;
    if (load_en) cfg_d = ppoll_cfg_t'(aux_data[CFG_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg_q <= CFG_RESET;
    else if (load_en) cfg_q <= cfg_d;
  end
endmodule

// File: rtl/ppoll_resp.sv
module ppoll_resp
  import ppoll_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  ppoll_cfg_t           cfg,
  input  logic                 ist,
  input  logic                 atn,
  input  logic                 eoi,
  output logic [DIO_LINES-1:0] pull_q,
  output logic                 od_q
);
  logic                 poll_hit;
  logic                 armed;
  logic [DIO_LINES-1:0] pull_d;

  always_comb begin
    poll_hit = atn & eoi;
    armed    = poll_hit & ~cfg.unc & (ist == cfg.sense);
  end

  for (genvar i = 0; i < DIO_LINES; i++) begin : g_line
    always_comb pull_d[i] = armed & (cfg.line == IDX_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pull_q <= '0;
      od_q   <= 1'b0;
    end else begin
      pull_q <= pull_d;
      od_q   <= poll_hit;
    end
  end
endmodule

// File: rtl/ppoll_responder.sv
module ppoll_responder
  import ppoll_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 aux_wr,
  input  logic [CMD_W-1:0]     aux_data,
  input  logic                 ist,
  input  logic                 atn,
  input  logic                 eoi,
  output logic [DIO_LINES-1:0] dio_pull_low,
  output logic                 dio_open_drain,
  output logic [CFG_W-1:0]     cfg_rd
);
  logic       rst_int_n;
  ppoll_cfg_t cfg;

  ppoll_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  ppoll_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_int_n), .aux_wr(aux_wr), .aux_data(aux_data), .cfg_q(cfg)
  );

  ppoll_resp u_resp (
    .clk(clk), .rst_n(rst_int_n), .cfg(cfg), .ist(ist), .atn(atn), .eoi(eoi),
    .pull_q(dio_pull_low), .od_q(dio_open_drain)
  );

  assign cfg_rd = cfg;
endmodule

// File: rtl/ppoll_responder_chk.sv
module ppoll_responder_chk
  import ppoll_pkg::*;
(
  input logic                 clk,
  input logic                 rst_int_n,
  input logic                 aux_wr,
  input logic [CMD_W-1:0]     aux_data,
  input logic                 ist,
  input logic                 atn,
  input logic                 eoi,
  input logic [DIO_LINES-1:0] dio_pull_low,
  input logic                 dio_open_drain,
  input logic [CFG_W-1:0]     cfg_rd
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_int_n |-> (dio_pull_low == '0 && !dio_open_drain)); // R1

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (aux_wr && aux_data[CMD_W-1 -: OP_W] == OP_PP_CFG) |=> cfg_rd == $past(aux_data[CFG_W-1:0])); // R2

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (aux_wr && aux_data[CMD_W-1 -: OP_W] != OP_PP_CFG) |=> $stable(cfg_rd)); // R3

  AST_UNCFG_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    cfg_rd[CFG_W-1] |=> dio_pull_low == '0); // R4

  AST_PULL_NEEDS_POLL: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(atn && eoi) |=> dio_pull_low == '0); // R8

  AST_OD_FOLLOWS_POLL: assert property (@(posedge clk) disable iff (!rst_int_n)
    (atn && eoi) |=> dio_open_drain); // R9

  AST_OD_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(atn && eoi) |=> !dio_open_drain); // R9

  AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(dio_pull_low)); // R10

  AST_SENSE_MATCH: assert property (@(posedge clk) disable iff (!rst_int_n)
    (atn && eoi && !cfg_rd[CFG_W-1] && ist == cfg_rd[CFG_W-2]) |=> $countones(dio_pull_low) == 1); // R11
endmodule

bind ppoll_responder ppoll_responder_chk u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .aux_wr(aux_wr), .aux_data(aux_data),
  .ist(ist), .atn(atn), .eoi(eoi), .dio_pull_low(dio_pull_low),
  .dio_open_drain(dio_open_drain), .cfg_rd(cfg_rd)
);

// File: tb/ppoll_responder_bench.sv
module ppoll_responder_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       aux_wr;
  logic [7:0] aux_data;
  logic       ist, atn, eoi;
  logic [7:0] dio_pull_low;
  logic       dio_open_drain;
  logic [4:0] cfg_rd;

  int checks   = 0;
  int failures = 0;
  bit mon_on   = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    logic [4:0] cfg;
    logic [7:0] dio;
    logic       od;
    string      tag;
  } exp_t;
  exp_t q[$];
  logic [4:0] m_cfg;

  always #10 clk = ~clk;

  ppoll_responder u_ppoll_responder (
    .clk(clk), .rst_n(rst_n), .aux_wr(aux_wr), .aux_data(aux_data),
    .ist(ist), .atn(atn), .eoi(eoi), .dio_pull_low(dio_pull_low),
    .dio_open_drain(dio_open_drain), .cfg_rd(cfg_rd)
  );

  task automatic check_now(input string tag, input logic [4:0] ec,
                           input logic [7:0] ed, input logic eo);
    checks++;
    if (cfg_rd !== ec || dio_pull_low !== ed || dio_open_drain !== eo) begin
      failures++;
      $display("FAIL %s actual cfg=%b dio=%b od=%b expected cfg=%b dio=%b od=%b",
               tag, cfg_rd, dio_pull_low, dio_open_drain, ec, ed, eo);
    end
  endtask

  // driver: apply one cycle of stimulus and push the expected post-edge outputs
  task automatic step(input logic wr, input logic [7:0] d, input logic i,
                      input logic a, input logic e, input string tag);
    exp_t x;
    @(negedge clk);
    aux_wr = wr; aux_data = d; ist = i; atn = a; eoi = e;
    x.od  = a & e;
    x.dio = (x.od && !m_cfg[4] && m_cfg[3] == i) ? (8'd1 << m_cfg[2:0]) : 8'd0;
    if (wr && d[7:5] == 3'b011) m_cfg = d[4:0];
    x.cfg = m_cfg;
    x.tag = tag;
    q.push_back(x);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, tag);
  endtask

  // monitor: compare a quarter period after every rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (mon_on && q.size() > 0) begin
        exp_t x;
        x = q.pop_front();
        check_now(x.tag, x.cfg, x.dio, x.od);
      end
    end
  end

  initial begin
    #3000000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; aux_wr = 1'b0; aux_data = '0; ist = 1'b0; atn = 1'b0; eoi = 1'b0;
    m_cfg = 5'b10000;
    repeat (3) @(negedge clk);
    check_now("R1 in reset", 5'b10000, 8'd0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_now("R1 after release", 5'b10000, 8'd0, 1'b0);
    mon_on = 1'b1;

    // unconfigured: polls do not pull any line, drivers still switch (R4, R9)
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, "R4 poll while reset-unconfigured ist0");
    step(1'b0, 8'h00, 1'b1, 1'b1, 1'b1, "R4 poll while reset-unconfigured ist1");
    idle("R9 idle");

    // DIO1 reverse phase (R2, R6, R7)
    step(1'b1, 8'b0110_0000, 1'b0, 1'b0, 1'b0, "R2 load 0110_0000");
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, "R6 reverse ist0 pulls DIO1");
    step(1'b0, 8'h00, 1'b1, 1'b1, 1'b1, "R6 reverse ist1 quiet");
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, "R11 ist back to 0");
    idle("R8 poll end clears");

    // partial poll conditions (R8)
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, "R8 atn only");
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, "R8 eoi only");

    // DIO2 in phase (R5)
    step(1'b1, 8'b0110_1001, 1'b0, 1'b0, 1'b0, "R2 load 0110_1001");
    step(1'b0, 8'h00, 1'b1, 1'b1, 1'b1, "R5 in phase ist1 pulls DIO2");
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, "R5 in phase ist0 quiet");

    // rejected opcodes (R3), then poll shows old config still active
    step(1'b1, 8'b1000_0111, 1'b1, 1'b0, 1'b0, "R3 opcode 100 ignored");
    step(1'b1, 8'b0111_0000 ^ 8'b0001_0000 ^ 8'b0010_0000, 1'b1, 1'b0, 1'b0, "R3 opcode 010 ignored");
    step(1'b1, 8'b1110_0101, 1'b1, 1'b0, 1'b0, "R3 opcode 111 ignored");
    step(1'b0, 8'b0110_0111, 1'b1, 1'b1, 1'b1, "R3 data without strobe ignored");
    step(1'b0, 8'h00, 1'b1, 1'b1, 1'b1, "R3 old config still answers");

    // write during poll takes effect one edge later (R11)
    step(1'b1, 8'b0110_1101, 1'b1, 1'b1, 1'b1, "R11 write during poll uses old cfg");
    step(1'b0, 8'h00, 1'b1, 1'b1, 1'b1, "R11 new line after write");

    // sweep every line index in both senses (R7, R10)
    for (int p = 0; p < 8; p++) begin
      for (int s = 0; s < 2; s++) begin
        step(1'b1, {3'b011, 1'b0, s[0], p[2:0]}, 1'b0, 1'b0, 1'b0, "R7 load index");
        step(1'b0, 8'h00, s[0], 1'b1, 1'b1, "R7 matching ist pulls line P");
        step(1'b0, 8'h00, ~s[0], 1'b1, 1'b1, "R10 mismatching ist quiet");
      end
    end

    // unconfigure by command (R4)
    step(1'b1, 8'b0111_0000, 1'b0, 1'b0, 1'b0, "R4 unconfigure 0111_0000");
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, "R4 unconfigured ist0 quiet");
    step(1'b0, 8'h00, 1'b1, 1'b1, 1'b1, "R4 unconfigured ist1 quiet");
    step(1'b1, 8'b0111_1111, 1'b1, 1'b0, 1'b0, "R4 unconfigure with other bits");
    step(1'b0, 8'h00, 1'b1, 1'b1, 1'b1, "R4 still quiet");
    idle("R9 final idle");
    idle("R9 final idle");

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule